// File: doc/BRIEF.md
# Coin-Operated Dispenser Controller

This block is a Moore state machine that tallies the value of coins dropped through a single slot and asserts a release command once the item price of 15 cents has been reached. The coin sensor reports a 5-cent coin and a 10-cent coin on two separate one-cycle pulses, synchronous to the clock.

Credit is kept as one of four symbolic states: empty, five, ten, and paid (15 cents or more). When the machine reaches the paid state it stays there whatever the sensor reports, and any overpayment is kept with no change returned. Only reset clears it. The release output is decoded from the state alone.

Top module: `coin_vend_ctrl`

## Requirements
- R1: While rst_ni is low, the state is empty (encoding 2'b00) and open_o is 0. The first clock edge after rst_ni rises starts from empty.
- R2: The credit states are encoded as empty=2'b00, five=2'b01, ten=2'b10 and paid=2'b11.
- R3: open_o is 1 exactly when the state is paid. It depends on no input.
- R4: In a cycle with no coin pulse, or with both pulses high (illegal, treated as no coin), the state does not change.
- R5: A 5-cent pulse advances the state by one step: empty to five, five to ten, ten to paid.
- R6: A 10-cent pulse advances the state by two steps, saturating at paid: empty to ten, five to paid, ten to paid.
- R7: Once paid, the state stays paid under any inputs until reset. Overpayment gives no change.
- R8: open_o rises in the cycle after the coin that completes 15 cents. This holds for each of these sequences: three nickels, nickel then dime, dime then nickel, two nickels then dime, and two dimes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nickel_i | input | 1 | One-cycle pulse for a 5-cent coin |
| dime_i | input | 1 | One-cycle pulse for a 10-cent coin |
| open_o | output | 1 | Release command, high in the paid state |

## Verification
On every cycle the assertions check the following: the output decode matches the paid state, the state holds when there is no coin and when both pulses are high, a nickel moves one step, a dime moves two steps with saturation, and the paid state is absorbing. Only the bench scenarios can show the full coin sequences from empty. These include the cycle in which open_o first rises after the final coin, and the way reset clears a paid machine so that a new purchase can start.

// File: rtl/coin_vend_pkg.sv
package coin_vend_pkg;
  localparam int unsigned CREDIT_W = 2;
  typedef enum logic [CREDIT_W-1:0] {
    CR_EMPTY = 2'b00,
    CR_FIVE  = 2'b01,
    CR_TEN   = 2'b10,
    CR_PAID  = 2'b11
  } credit_e;
  typedef enum logic [1:0] {
    COIN_NONE,
    COIN_NICKEL,
    COIN_DIME
  } coin_e;
endpackage

// File: rtl/coin_decode.sv
module coin_decode
  import coin_vend_pkg::*;
(
  input  logic  nickel_i,
  input  logic  dime_i,
  output coin_e coin_o
);
  always_comb begin
    unique case ({dime_i, nickel_i})
      2'b01:   coin_o = COIN_NICKEL;
      2'b10:   coin_o = COIN_DIME;
      default: coin_o = COIN_NONE; // both high: illegal, ignored (R4)
    endcase
  end
endmodule

// File: rtl/credit_next.sv
module credit_next
  import coin_vend_pkg::*;
(
  input  credit_e cur_i,
  input  coin_e   coin_i,
  output credit_e nxt_o
);
  localparam int unsigned STEP_W = CREDIT_W + 1;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] sum;

  always_comb begin
    unique case (coin_i)
      COIN_NICKEL: step = STEP_W'(1);
      COIN_DIME:   step = STEP_W'(2);
      default:     step = '0;
    endcase
    sum = STEP_W'(cur_i) + step;
    // saturate at paid, paid is absorbing
    if (cur_i == CR_PAID || sum >= STEP_W'(CR_PAID)) nxt_o = CR_PAID;
    else                                             nxt_o = credit_e'(sum[CREDIT_W-1:0]);
  end
endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
  import coin_vend_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nickel_i,
  input  logic dime_i,
  output logic open_o
);
  coin_e   coin;
  credit_e credit_q, credit_d;

  coin_decode u_dec (
    .nickel_i (nickel_i),
    .dime_i   (dime_i),
    .coin_o   (coin)
  );

  credit_next u_nxt (
    .cur_i  (credit_q),
    .coin_i (coin),
    .nxt_o  (credit_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) credit_q <= CR_EMPTY;
    else         credit_q <= credit_d;
  end

  assign open_o = (credit_q == CR_PAID);

  p_reset_empty_r1: assert property (@(posedge clk_i)
    !rst_ni |=> credit_q == CR_EMPTY);

  p_open_decode_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_o == (credit_q == CR_PAID));

  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nickel_i == dime_i) |=> $stable(credit_q));

  p_nickel_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nickel_i && !dime_i && credit_q != CR_PAID) |=>
      credit_q == credit_e'($past(credit_q) + 2'd1));

  p_dime_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dime_i && !nickel_i && credit_q != CR_PAID) |=>
      credit_q == (($past(credit_q) == CR_EMPTY) ? CR_TEN : CR_PAID));

  p_paid_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_o |=> open_o);
endmodule

// File: tb/coin_vend_ctrl_tb.sv
module coin_vend_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nickel = 1'b0;
  logic dime = 1'b0;
  logic open_w;
  int   total = 0;
  int   bad = 0;

  always #10 clk = ~clk; // 50 MHz

  coin_vend_ctrl u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .nickel_i (nickel),
    .dime_i   (dime),
    .open_o   (open_w)
  );

  // coin codes: 0 none, 1 nickel, 2 dime, 3 both
  localparam int NSEQ = 5;
  localparam int SLEN = 4;
  localparam logic [1:0] SEQ_COINS [NSEQ][SLEN] = '{
    '{2'd1, 2'd1, 2'd1, 2'd0},
    '{2'd1, 2'd2, 2'd0, 2'd0},
    '{2'd2, 2'd1, 2'd0, 2'd0},
    '{2'd1, 2'd1, 2'd2, 2'd0},
    '{2'd2, 2'd2, 2'd0, 2'd0}
  };
  localparam logic SEQ_OPEN [NSEQ][SLEN] = '{
    '{1'b0, 1'b0, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 1'b1},
    '{1'b0, 1'b0, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 1'b1}
  };

  task automatic check(input logic exp, input string req);
    total++;
    if (open_w !== exp) begin
      bad++;
      $display("FAIL %s open_o=%b expected=%b", req, open_w, exp);
    end
  endtask

  // drive coins on negedge; after posedge, sample at next negedge
  task automatic step(input logic [1:0] c);
    nickel = c[0];
    dime   = c[1];
    @(negedge clk);
    nickel = 1'b0;
    dime   = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    check(1'b0, "R1 in reset");
    do_reset();
    check(1'b0, "R1 after reset");

    // R8 sequences with R5/R6 stepping
    for (int s = 0; s < NSEQ; s++) begin
      do_reset();
      for (int k = 0; k < SLEN; k++) begin
        step(SEQ_COINS[s][k]);
        check(SEQ_OPEN[s][k], "R8 sequence");
      end
      for (int k = 0; k < 3; k++) begin
        step(2'd0);
        check(1'b1, "R7 stays paid");
      end
    end

    // R7: extra coins after paid change nothing
    step(2'd1); check(1'b1, "R7 nickel when paid");
    step(2'd2); check(1'b1, "R7 dime when paid");
    step(2'd3); check(1'b1, "R7 both when paid");
    do_reset();
    check(1'b0, "R1 reset clears paid");

    // R4: idle and illegal both-high hold; reach ten then nickel reveals state
    step(2'd2); check(1'b0, "R6 dime to ten");
    for (int k = 0; k < 5; k++) begin step(2'd0); check(1'b0, "R4 idle"); end
    step(2'd3); check(1'b0, "R4 both-high ignored");
    step(2'd3); check(1'b0, "R4 both-high ignored");
    step(2'd1); check(1'b1, "R5 ten plus nickel paid");

    // R4 at empty: both-high must not add credit; then two nickels not yet paid
    do_reset();
    step(2'd3); step(2'd3);
    step(2'd1); check(1'b0, "R4 empty both-high");
    step(2'd1); check(1'b0, "R5 ten not paid");
    step(2'd1); check(1'b1, "R5 third nickel");

    // R3/R2: five then dime saturates to paid
    do_reset();
    step(2'd1); check(1'b0, "R2 five not paid");
    step(2'd2); check(1'b1, "R6 five plus dime");
    check(1'b1, "R3 open held between edges");

    // R1: reset mid-credit then nickel from empty
    do_reset();
    step(2'd1); step(2'd1);
    do_reset();
    step(2'd1); check(1'b0, "R1 credit cleared");
    step(2'd2); check(1'b1, "R1 five plus dime after reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule